// File: doc/BRIEF.md
# SYSREF Pulser with Divider Synchronisation

This controller sits in a clock distributor for converter links of the JESD204B kind. It runs entirely from the fast reference clock. It holds a set of programmable device-clock dividers and one SYSREF divider. A single SYNC request can take one of two actions, depending on the programmed mode. The request comes either from a pin or from flipping a polarity bit in configuration.

In the first mode, SYNC restarts the dividers so that their phases line up. In the second mode, SYNC launches a counted burst of SYSREF pulses, and those pulses are timed by the SYSREF divider. A typical bring-up runs in three steps:

1. Align the dividers with the first mode.
2. Set each divider's sync-disable bit, so that later SYNC events leave the dividers alone.
3. Switch to the second mode and route the pulser to the SYSREF output.

A local delay-clear input keeps the SYSREF output path quiet until the path has been cleared for a minimum time after power-up.

All divide values, burst lengths and routing choices come from static configuration inputs. The divide ratios work as ratios of the reference clock. From a 3000 MHz reference, a value of 4 gives 750 MHz, 20 gives 150 MHz, and 300 gives a 10 MHz SYSREF.

Top module: `sysref_ctrl`

## Requirements
- R1: Each divider output repeats with a period equal to its divide value, and any value below 2 acts as 2. After a restart the output is low for the first floor(D/2) reference cycles of each period and high for the rest.
- R2: The effective SYNC is the pin, passed through two synchroniser flops, XOR the polarity bit, and then registered once. Only its rising edge is an event, so a held level or a falling edge does nothing. A polarity change makes its event act at the second clock edge after the change. A pin change makes its event act at the fourth clock edge.
- R3: No event has any effect when sync enable is 0, or when the sync mode is 0 or 3.
- R4: In sync mode 1 (2'b01), an event restarts every divider whose disable bit is clear at count zero with its output low. Those dividers then share one phase.
- R5: Disable bit i of the device-clock disable vector protects device-clock divider i, and a separate bit protects the SYSREF divider. A protected divider keeps its phase through an event.
- R6: In sync mode 2 (2'b10), an event arms a burst of (pulse count field + 1) pulses. The burst begins at the next SYSREF divider period boundary. Each pulse fills one divider period, so consecutive rising edges are one SYSREF divide value apart.
- R7: An event that arrives while a burst is armed or running is ignored. After the last pulse the output stays low until the next accepted event.
- R8: The SYSREF source select picks what drives the SYSREF output: 0 is the effective SYNC level, 1 is the free-running SYSREF divider, 2 is the pulser, and 3 is constant low.
- R9: The SYSREF output is held low while the SYSREF power-down bit is 1 or the delay-clear bit is 1. It also stays low until delay-clear has been asserted for 15 reference cycles in total since power-down last went low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | Asynchronous SYNC request pin |
| cfg_sync_pol | input | 1 | Polarity bit XORed with the synchronised pin |
| cfg_sync_en | input | 1 | Master enable for SYNC events |
| cfg_sync_mode | input | 2 | 1: restart dividers, 2: start pulser, 0/3: no action |
| cfg_dclk_div | input | N_DCLK*DIV_W | Packed device-clock divide values, divider i in slice i |
| cfg_dclk_sync_dis | input | N_DCLK | Per device-clock divider sync disable |
| cfg_sysref_div | input | DIV_W | SYSREF divide value |
| cfg_sysref_sync_dis | input | 1 | SYSREF divider sync disable |
| cfg_pulse_cnt | input | CNT_W | Pulses per burst minus one |
| cfg_sysref_pd | input | 1 | SYSREF path power-down |
| cfg_dly_clr | input | 1 | Local SYSREF delay clear |
| cfg_sysref_sel | input | 2 | SYSREF output source select |
| dclk_out | output | N_DCLK | Device-clock divider outputs |
| sysref_out | output | 1 | SYSREF output |

## Verification
The assertions assume three things about the inputs:

- The divide values stay constant between SYNC events.
- The pulse-count field stays constant while a burst is armed or running.
- The configuration inputs are synchronous to the reference clock.

The bench meets these assumptions in three ways. It changes every configuration input on the falling clock edge. It reprograms the burst length only after the previous burst has had time to finish. It changes divide values only in the period test, before any alignment check. Only the SYNC pin is treated as asynchronous, and the bench still drives it away from the active edge so that the pin latency it checks is exact.

// File: rtl/sysref_pkg.sv
// Shared encodings for the SYSREF controller.
package sysref_pkg;

    // What a SYNC event does.
    typedef enum logic [1:0] {
        SM_OFF       = 2'd0,
        SM_DIV_RESET = 2'd1,
        SM_PULSER    = 2'd2,
        SM_RSVD      = 2'd3
    } sync_mode_e;

    // Source of the SYSREF output.
    typedef enum logic [1:0] {
        SR_SYNC_LEVEL = 2'd0,
        SR_DIVIDER    = 2'd1,
        SR_PULSER     = 2'd2,
        SR_QUIET      = 2'd3
    } sr_sel_e;

    // Pulser sequencing.
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_ARMED  = 2'd1,
        PS_ACTIVE = 2'd2
    } pulser_state_e;

endpackage

// File: rtl/sysref_sync_edge.sv
// SYNC front end: brings the pin into the reference domain through two flops,
// applies the polarity bit, registers the result and reports its rising edge.
// Assumes the polarity and enable bits are synchronous to clk.
module sysref_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin,
    input  logic sync_pol,
    input  logic sync_en,
    output logic sync_level,
    output logic sync_evt
);

    logic meta_q;
    logic stable_q;
    logic eff_q;
    logic eff_prev_q;

    // Two-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= sync_pin;
            stable_q <= meta_q;
        end
    end

    // Registered effective SYNC level and its previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q      <= 1'b0;
            eff_prev_q <= 1'b0;
        end else begin
            eff_q      <= stable_q ^ sync_pol;
            eff_prev_q <= eff_q;
        end
    end

    assign sync_level = eff_q;
    assign sync_evt   = sync_en && eff_q && !eff_prev_q;

    // An event is a single-cycle strobe, so a held level cannot retrigger.
    p_single_strobe_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> !sync_evt);

endmodule

// File: rtl/sysref_clk_div.sv
// Programmable divider: counts 0..D-1 and outputs low for the first half of
// the period. A sync restart returns the count to zero unless disabled.
// Assumes div_val stays constant between restarts; values below 2 act as 2.
module sysref_clk_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_val,
    input  logic         sync_rst,
    input  logic         sync_dis,
    output logic         div_out,
    output logic         wrap
);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;
    logic         restart;

    assign lim     = (div_val < W'(2)) ? W'(2) : div_val;
    assign restart = sync_rst && !sync_dis;
    assign wrap    = (cnt >= lim - W'(1));
    assign div_out = (cnt >= (lim >> 1));

    // Period counter with sync restart taking priority over the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    // A restart leaves the output low at count zero.
    p_restart_low_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!div_out && cnt == '0));

    // The count returns to zero after the last count of a period.
    p_wrap_zero_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !restart) |=> (cnt == '0));

endmodule

// File: rtl/sysref_pulser.sv
// Burst pulser: a trigger arms it, the next SYSREF period boundary starts
// the burst, and it then gates the divider output for (burst_cfg + 1)
// periods. Triggers are ignored unless idle. Assumes burst_cfg is stable
// while a burst is armed or running.
module sysref_pulser
    import sysref_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          period_end,
    input  logic          div_level,
    input  logic [CW-1:0] burst_cfg,
    output logic          pulse_out
);

    pulser_state_e state;
    logic [CW-1:0] left;

    // Sequence idle -> armed -> active and count the remaining periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            left  <= '0;
        end else begin
            case (state)
                PS_IDLE: begin
                    if (trig) state <= PS_ARMED;
                end
                PS_ARMED: begin
                    if (period_end) begin
                        state <= PS_ACTIVE;
                        left  <= burst_cfg;
                    end
                end
                PS_ACTIVE: begin
                    if (period_end) begin
                        if (left == '0) state <= PS_IDLE;
                        else            left  <= left - CW'(1);
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    assign pulse_out = (state == PS_ACTIVE) && div_level;

    // A trigger while busy leaves the burst untouched.
    p_retrig_ignored_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_IDLE && trig && !period_end) |=> ($stable(state) && $stable(left)));

    // Remaining periods never exceed the programmed count.
    p_burst_bound_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE) |-> (left <= burst_cfg));

    // The output is low once the final period has ended.
    p_quiet_after_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && period_end && left == '0) |=> !pulse_out);

endmodule

// File: rtl/sysref_ctrl.sv
// SYSREF controller top: SYNC front end, device-clock dividers, SYSREF
// divider, burst pulser, output source select and local delay-clear hold.
// Assumes all cfg_* inputs are synchronous to clk; sync_pin may be async.
module sysref_ctrl
    import sysref_pkg::*;
#(
    parameter int N_DCLK  = 3,
    parameter int DIV_W   = 12,
    parameter int CNT_W   = 2,
    parameter int CLR_MIN = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync_pin,
    input  logic                      cfg_sync_pol,
    input  logic                      cfg_sync_en,
    input  logic [1:0]                cfg_sync_mode,
    input  logic [N_DCLK*DIV_W-1:0]   cfg_dclk_div,
    input  logic [N_DCLK-1:0]         cfg_dclk_sync_dis,
    input  logic [DIV_W-1:0]          cfg_sysref_div,
    input  logic                      cfg_sysref_sync_dis,
    input  logic [CNT_W-1:0]          cfg_pulse_cnt,
    input  logic                      cfg_sysref_pd,
    input  logic                      cfg_dly_clr,
    input  logic [1:0]                cfg_sysref_sel,
    output logic [N_DCLK-1:0]         dclk_out,
    output logic                      sysref_out
);

    localparam int CLR_W = $clog2(CLR_MIN + 1);

    sync_mode_e         mode;
    sr_sel_e            sel;
    logic               sync_level;
    logic               sync_evt;
    logic               div_rst;
    logic               pulse_trig;
    logic [N_DCLK-1:0]  dclk_wrap;
    logic               sr_div_out;
    logic               sr_wrap;
    logic               pulse_out;
    logic [CLR_W-1:0]   clr_cnt;
    logic               dly_hold;
    logic               sr_mux;

    assign mode       = sync_mode_e'(cfg_sync_mode);
    assign sel        = sr_sel_e'(cfg_sysref_sel);
    assign div_rst    = sync_evt && (mode == SM_DIV_RESET);
    assign pulse_trig = sync_evt && (mode == SM_PULSER);

    sysref_sync_edge u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pin   (sync_pin),
        .sync_pol   (cfg_sync_pol),
        .sync_en    (cfg_sync_en),
        .sync_level (sync_level),
        .sync_evt   (sync_evt)
    );

    // One divider per device clock, each with its own sync disable.
    for (genvar i = 0; i < N_DCLK; i++) begin : g_dclk
        sysref_clk_div #(.W(DIV_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_val  (cfg_dclk_div[i*DIV_W +: DIV_W]),
            .sync_rst (div_rst),
            .sync_dis (cfg_dclk_sync_dis[i]),
            .div_out  (dclk_out[i]),
            .wrap     (dclk_wrap[i])
        );

        // A restarted divider is at the start of a period, never at its end.
        p_no_wrap_after_restart_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            (div_rst && !cfg_dclk_sync_dis[i]) |=> !dclk_wrap[i]);
    end

    sysref_clk_div #(.W(DIV_W)) u_sr_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_val  (cfg_sysref_div),
        .sync_rst (div_rst),
        .sync_dis (cfg_sysref_sync_dis),
        .div_out  (sr_div_out),
        .wrap     (sr_wrap)
    );

    sysref_pulser #(.CW(CNT_W)) u_pulser (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (pulse_trig),
        .period_end (sr_wrap),
        .div_level  (sr_div_out),
        .burst_cfg  (cfg_pulse_cnt),
        .pulse_out  (pulse_out)
    );

    // Accumulate delay-clear time since the SYSREF path left power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt <= '0;
        end else if (cfg_sysref_pd) begin
            clr_cnt <= '0;
        end else if (cfg_dly_clr && clr_cnt != CLR_W'(CLR_MIN)) begin
            clr_cnt <= clr_cnt + CLR_W'(1);
        end
    end

    assign dly_hold = cfg_sysref_pd || cfg_dly_clr || (clr_cnt != CLR_W'(CLR_MIN));

    // Pick the SYSREF source.
    always_comb begin
        case (sel)
            SR_SYNC_LEVEL: sr_mux = sync_level;
            SR_DIVIDER:    sr_mux = sr_div_out;
            SR_PULSER:     sr_mux = pulse_out;
            SR_QUIET:      sr_mux = 1'b0;
            default:       sr_mux = 1'b0;
        endcase
    end

    assign sysref_out = !dly_hold && sr_mux;

    // SYSREF only appears once the clear has been held for the minimum time.
    p_clr_gate_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        sysref_out |-> (clr_cnt == CLR_W'(CLR_MIN) && !cfg_dly_clr));

endmodule

// File: tb/sysref_ctrl_bench.sv
module sysref_ctrl_bench;

    localparam int N_DCLK = 3;
    localparam int DIV_W  = 12;
    localparam int CNT_W  = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sync_pin = 1'b0;
    logic                    cfg_sync_pol = 1'b0;
    logic                    cfg_sync_en = 1'b0;
    logic [1:0]              cfg_sync_mode = 2'd0;
    logic [N_DCLK*DIV_W-1:0] cfg_dclk_div = '0;
    logic [N_DCLK-1:0]       cfg_dclk_sync_dis = '0;
    logic [DIV_W-1:0]        cfg_sysref_div = '0;
    logic                    cfg_sysref_sync_dis = 1'b0;
    logic [CNT_W-1:0]        cfg_pulse_cnt = '0;
    logic                    cfg_sysref_pd = 1'b1;
    logic                    cfg_dly_clr = 1'b0;
    logic [1:0]              cfg_sysref_sel = 2'd1;
    logic [N_DCLK-1:0]       dclk_out;
    logic                    sysref_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    sysref_ctrl u_sysref_ctrl (
        .clk                 (clk),
        .rst_n               (rst_n),
        .sync_pin            (sync_pin),
        .cfg_sync_pol        (cfg_sync_pol),
        .cfg_sync_en         (cfg_sync_en),
        .cfg_sync_mode       (cfg_sync_mode),
        .cfg_dclk_div        (cfg_dclk_div),
        .cfg_dclk_sync_dis   (cfg_dclk_sync_dis),
        .cfg_sysref_div      (cfg_sysref_div),
        .cfg_sysref_sync_dis (cfg_sysref_sync_dis),
        .cfg_pulse_cnt       (cfg_pulse_cnt),
        .cfg_sysref_pd       (cfg_sysref_pd),
        .cfg_dly_clr         (cfg_dly_clr),
        .cfg_sysref_sel      (cfg_sysref_sel),
        .dclk_out            (dclk_out),
        .sysref_out          (sysref_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Edge monitor: channels 0..2 are device clocks, 3 is SYSREF.
    int   last_rise [4];
    int   period    [4];
    int   rises     [4];
    logic [3:0] prev = '0;
    initial for (int i = 0; i < 4; i++) begin
        last_rise[i] = 0; period[i] = 0; rises[i] = 0;
    end
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if ({sysref_out, dclk_out}[i] && !prev[i]) begin
                period[i]    = cyc - last_rise[i];
                last_rise[i] = cyc;
                rises[i]     = rises[i] + 1;
            end
        end
        prev = {sysref_out, dclk_out};
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Latest rise of channel ch must sit D/2 after a multiple of D from E.
    task automatic phase_check(int ch, int e, int d, string req);
        int r, m;
        @(posedge clk);
        r = last_rise[ch];
        m = ((r - e) % d + d) % d;
        check(r > e && m == d / 2, req, m, d / 2);
        @(negedge clk);
    endtask

    task automatic t_reset();
        step(1);
        check(dclk_out == '0, "R1 reset dclk", int'(dclk_out), 0);
        check(sysref_out == 1'b0, "R9 reset sysref", int'(sysref_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_clear();
        int r0;
        cfg_sysref_sel = 2'd1;
        r0 = rises[3]; step(30); @(posedge clk);
        check(rises[3] == r0, "R9 powered down", rises[3] - r0, 0);
        @(negedge clk);
        cfg_sysref_pd = 1'b0; cfg_dly_clr = 1'b1; step(5); cfg_dly_clr = 1'b0;
        r0 = rises[3]; step(40); @(posedge clk);
        check(rises[3] == r0, "R9 short clear", rises[3] - r0, 0);
        @(negedge clk);
        cfg_dly_clr = 1'b1; r0 = rises[3]; step(12); @(posedge clk);
        check(rises[3] == r0, "R9 during clear", rises[3] - r0, 0);
        @(negedge clk);
        cfg_dly_clr = 1'b0; r0 = rises[3]; step(65); @(posedge clk);
        check(rises[3] - r0 >= 2, "R9 released", rises[3] - r0, 3);
        check(period[3] == 20, "R8 divider source period", period[3], 20);
        @(negedge clk);
        cfg_sysref_pd = 1'b1; step(2); cfg_sysref_pd = 1'b0;
        r0 = rises[3]; step(40); @(posedge clk);
        check(rises[3] == r0, "R9 clear needed again", rises[3] - r0, 0);
        @(negedge clk);
        cfg_dly_clr = 1'b1; step(16); cfg_dly_clr = 1'b0; step(10);
    endtask

    task automatic t_period();
        step(50); @(posedge clk);
        check(period[0] == 4, "R1 div 4 ch0", period[0], 4);
        check(period[1] == 4, "R1 div 4 ch1", period[1], 4);
        check(period[2] == 20, "R1 div 20", period[2], 20);
        @(negedge clk);
        cfg_dclk_div[2*DIV_W +: DIV_W] = 12'd1; step(30); @(posedge clk);
        check(period[2] == 2, "R1 div 1 acts as 2", period[2], 2);
        @(negedge clk);
        cfg_dclk_div[2*DIV_W +: DIV_W] = 12'd7; step(40); @(posedge clk);
        check(period[2] == 7, "R1 div 7", period[2], 7);
        @(negedge clk);
        cfg_dclk_div[2*DIV_W +: DIV_W] = 12'd20; step(30);
    endtask

    int e1, e2;

    task automatic t_align();
        cfg_sync_en = 1'b1; cfg_sync_mode = 2'd1; cfg_dclk_sync_dis = '0;
        cfg_sysref_sync_dis = 1'b0; step(1);
        cfg_sync_pol = 1'b1; e1 = cyc + 2;
        step(60);
        phase_check(0, e1, 4, "R4 align ch0");
        phase_check(1, e1, 4, "R4 align ch1");
        phase_check(2, e1, 20, "R4 align ch2");
        phase_check(3, e1, 20, "R4 align sysref divider");
        cfg_sync_pol = 1'b0; step(50);
        phase_check(1, e1, 4, "R2 falling edge no event");
    endtask

    task automatic t_disable();
        cfg_dclk_sync_dis = 3'b001; cfg_sysref_sync_dis = 1'b1;
        while (((cyc + 2 - e1) % 4) != 2) step(1);
        cfg_sync_pol = 1'b1; e2 = cyc + 2;
        step(60);
        phase_check(0, e1, 4, "R5 disabled ch0 keeps phase");
        phase_check(1, e2, 4, "R5 enabled ch1 restarted");
        phase_check(2, e2, 20, "R5 enabled ch2 restarted");
        phase_check(3, e1, 20, "R5 disabled sysref keeps phase");
        cfg_sync_pol = 1'b0; step(10);
        cfg_dclk_sync_dis = '0;
    endtask

    task automatic t_inhibit();
        cfg_sync_en = 1'b0;
        while (((cyc + 2 - e2) % 4) != 1) step(1);
        cfg_sync_pol = 1'b1; step(40);
        phase_check(1, e2, 4, "R3 enable off");
        cfg_sync_pol = 1'b0; step(5);
        cfg_sync_en = 1'b1; cfg_sync_mode = 2'd0;
        while (((cyc + 2 - e2) % 4) != 3) step(1);
        cfg_sync_pol = 1'b1; step(40);
        phase_check(1, e2, 4, "R3 mode 0");
        cfg_sync_pol = 1'b0; step(5);
    endtask

    task automatic burst(int n, bit en, int expect_n);
        int r0;
        cfg_pulse_cnt = CNT_W'(n); cfg_sync_en = en; step(2);
        r0 = rises[3];
        cfg_sync_pol = 1'b1; step((n + 3) * 20 + 10);
        cfg_sync_pol = 1'b0; step(5); @(posedge clk);
        check(rises[3] - r0 == expect_n, "R6 burst pulse count", rises[3] - r0, expect_n);
        if (expect_n > 1)
            check(period[3] == 20, "R6 pulse spacing", period[3], 20);
        @(negedge clk);
    endtask

    task automatic t_burst();
        cfg_sync_mode = 2'd2; cfg_sysref_sel = 2'd2; cfg_sysref_sync_dis = 1'b1;
        step(5);
        burst(0, 1'b1, 1);
        burst(1, 1'b1, 2);
        burst(3, 1'b1, 4);
        burst(1, 1'b0, 0);   // R3: enable off, no burst
        cfg_sync_en = 1'b1;
    endtask

    task automatic t_retrig();
        int r0;
        cfg_pulse_cnt = 2'd2; step(2);
        r0 = rises[3];
        cfg_sync_pol = 1'b1; step(30);
        cfg_sync_pol = 1'b0; step(4);
        cfg_sync_pol = 1'b1; step(120);
        cfg_sync_pol = 1'b0; step(5); @(posedge clk);
        check(rises[3] - r0 == 3, "R7 retrigger ignored", rises[3] - r0, 3);
        @(negedge clk);
        r0 = rises[3]; step(100);
        check(sysref_out == 1'b0, "R7 low after burst", int'(sysref_out), 0);
        @(posedge clk);
        check(rises[3] == r0, "R7 no stray pulses", rises[3] - r0, 0);
        @(negedge clk);
        r0 = rises[3];
        sync_pin = 1'b1; step(250); @(posedge clk);
        check(rises[3] - r0 == 3, "R2 held pin one burst", rises[3] - r0, 3);
        @(negedge clk);
        sync_pin = 1'b0; step(5);
    endtask

    task automatic t_mux();
        int r0;
        cfg_sync_mode = 2'd0; cfg_sysref_sel = 2'd0; step(5);
        sync_pin = 1'b1; step(2);
        check(sysref_out == 1'b0, "R2 pin latency early", int'(sysref_out), 0);
        step(1);
        check(sysref_out == 1'b1, "R8 sync level source", int'(sysref_out), 1);
        sync_pin = 1'b0; step(5);
        cfg_sync_pol = 1'b1; step(2);
        check(sysref_out == 1'b1, "R2 polarity inverts", int'(sysref_out), 1);
        cfg_sysref_sel = 2'd3; step(1);
        r0 = rises[3]; step(40);
        check(sysref_out == 1'b0, "R8 quiet source", int'(sysref_out), 0);
        @(posedge clk);
        check(rises[3] == r0, "R8 quiet no edges", rises[3] - r0, 0);
        @(negedge clk);
        cfg_sync_pol = 1'b0; step(5);
    endtask

    initial begin
        cfg_dclk_div   = {12'd20, 12'd4, 12'd4};
        cfg_sysref_div = 12'd20;
        step(4);
        t_reset();
        t_clear();
        t_period();
        t_align();
        t_disable();
        t_inhibit();
        t_burst();
        t_retrig();
        t_mux();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule